// File: doc/BRIEF.md
# Single-Channel Peripheral Byte Mover with Early-End Strobe

This block is one DMA channel placed between a byte-wide serial bus peripheral and a synchronous memory port. Software programs a fixed device register address, a starting memory address and a byte count. It then sets the enable bit together with a direction bit. The channel then moves one byte for each request the peripheral raises. In transmit it reads memory and writes the device's data register whenever the peripheral reports its transmit buffer empty. In receive it reads the device's data register and writes memory whenever the peripheral reports a received byte.

After every moved byte the count drops by one and the memory address steps forward. When the count reaches zero the peripheral gets an end strobe. One transfer earlier, when exactly one byte is left, the channel gives a second strobe. A receiving bus master can use that early strobe to answer the final byte with a NACK. A half-way flag and a done flag can each drive their own interrupt line.

Top module: `pdma_chan`

## Requirements
- R1: After a synchronous reset every register reads zero, and every strobe, read, write and interrupt output is low.
- R2: Registers are selected by `cfg_addr`: 0 control (bit0 enable, bit1 direction, bit2 half interrupt enable, bit3 done interrupt enable, bits5:4 priority, stored and read back), 1 status (bit0 half flag, bit1 done flag), 2 device address, 3 memory address, 4 remaining count. A read strobe returns the selected value on `cfg_rdata` in the next cycle.
- R3: A byte move starts only when the channel is idle and all of the following hold: the enable bit is set, `dev_dma_en` is high, the count is nonzero, and the flag selected by the direction is high. Direction 1 selects `dev_tx_empty` and direction 0 selects `dev_rx_full`. The flag that the direction does not select is ignored.
- R4: Each accepted request gives a `dev_ack` pulse one cycle long, in the same cycle as the source read strobe. The destination write strobe follows exactly two cycles later and carries the byte returned one cycle after the read. No new request is accepted before the cycle after the write.
- R5: With direction 1 the source is memory at the memory address and the destination is the device at the device address. With direction 0 the source and destination are swapped. Memory and device are never written, or read, in the same cycle.
- R6: In the cycle after each write, the count falls by one and the memory address rises by one, wrapping at its width. The device address does not change.
- R7: When the count reaches zero, `dev_eot` pulses for one cycle, in the cycle after the last write, and the done flag is set.
- R8: When the count falls from two to one, `dev_eot_early` pulses for one cycle. A transfer programmed with a count of one gives no early strobe.
- R9: The half flag is set on the transfer that leaves the remaining count equal to the programmed count divided by two, rounded down.
- R10: `irq_half` is the half flag ANDed with its enable, and `irq_done` is the done flag ANDed with its enable. Writing one to a status bit clears that flag, and writing zero leaves it unchanged.
- R11: While the enable bit is set, writes to the device address, memory address and count registers are ignored.
- R12: A count of zero never produces a request acknowledge, even when every other start condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | RW | Register write data |
| cfg_rdata | output | RW | Registered read data |
| dev_dma_en | input | 1 | Peripheral permits DMA requests |
| dev_tx_empty | input | 1 | Peripheral transmit buffer empty |
| dev_rx_full | input | 1 | Peripheral holds a received byte |
| dev_ack | output | 1 | One-cycle request acknowledge |
| dev_eot | output | 1 | End-of-transfer strobe |
| dev_eot_early | output | 1 | Strobe when one byte remains |
| dev_addr | output | AW | Device data register address |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_rdata | input | DW | Device read data, one cycle after `dev_rd` |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_rd` |
| wdata | output | DW | Write data for either destination |
| irq_half | output | 1 | Half-way interrupt |
| irq_done | output | 1 | Transfer-complete interrupt |

## Verification
The bench builds the channel with an 8-bit address and a 6-bit count. With these values the largest count of 63 can be run to the end in a few hundred cycles, and a transmit run that starts near the top of memory carries the address past 0xFF and back to low values. The odd count puts the half-way point at an uneven place. Short receive runs of two bytes and one byte cover the case where the early strobe and the half flag fall on the first transfer, and the case where no early strobe is given.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_READ,
    XS_WAIT,
    XS_WRITE
  } xfer_state_e;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_STAT  = 3'd1;
  localparam logic [2:0] OFS_DADDR = 3'd2;
  localparam logic [2:0] OFS_MADDR = 3'd3;
  localparam logic [2:0] OFS_COUNT = 3'd4;

  localparam int CTRL_W = 6;

  typedef struct packed {
    logic [1:0] prio;
    logic       done_ie;
    logic       half_ie;
    logic       dir;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          step,
  output ctrl_t         ctrl_q,
  output logic [AW-1:0] daddr_q,
  output logic [AW-1:0] maddr_q,
  output logic [CW-1:0] cnt_q,
  output logic          half_q,
  output logic          done_q,
  output logic          eot_q,
  output logic          early_q
);

  logic [CW-1:0] prog_q;
  logic [CW-1:0] cnt_nx;
  logic [CW-1:0] half_mark;
  logic [RW-1:0] rd_mux;

  assign cnt_nx    = cnt_q - 1'b1;
  assign half_mark = prog_q >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      daddr_q <= '0;
      maddr_q <= '0;
      cnt_q   <= '0;
      prog_q  <= '0;
      half_q  <= 1'b0;
      done_q  <= 1'b0;
      eot_q   <= 1'b0;
      early_q <= 1'b0;
    end else begin
      eot_q   <= 1'b0;
      early_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          OFS_CTRL:  ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
          OFS_STAT: begin
            if (cfg_wdata[0]) half_q <= 1'b0;
            if (cfg_wdata[1]) done_q <= 1'b0;
          end
          OFS_DADDR: if (!ctrl_q.en) daddr_q <= cfg_wdata[AW-1:0];
          OFS_MADDR: if (!ctrl_q.en) maddr_q <= cfg_wdata[AW-1:0];
          OFS_COUNT: if (!ctrl_q.en) begin
            cnt_q  <= cfg_wdata[CW-1:0];
            prog_q <= cfg_wdata[CW-1:0];
          end
          default: ;
        endcase
      end
      if (step) begin
        cnt_q   <= cnt_nx;
        maddr_q <= maddr_q + 1'b1;
        if (cnt_nx == '0) begin
          eot_q  <= 1'b1;
          done_q <= 1'b1;
        end
        if (cnt_nx == CW'(1)) early_q <= 1'b1;
        if (cnt_nx == half_mark) half_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (cfg_addr)
      OFS_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      OFS_STAT:  rd_mux[1:0]        = {done_q, half_q};
      OFS_DADDR: rd_mux[AW-1:0]     = daddr_q;
      OFS_MADDR: rd_mux[AW-1:0]     = maddr_q;
      OFS_COUNT: rd_mux[CW-1:0]     = cnt_q;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_re) cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir,
  input  logic          cnt_nz,
  input  logic          dma_en,
  input  logic          tx_empty,
  input  logic          rx_full,
  input  logic [AW-1:0] daddr,
  input  logic [AW-1:0] maddr,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          ack,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] dev_addr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] wdata,
  output logic          step
);

  xfer_state_e st;
  logic        dir_q;
  logic        req;
  logic        go;

  assign req  = dir ? tx_empty : rx_full;
  assign go   = (st == XS_IDLE) && en && dma_en && cnt_nz && req;
  assign step = (st == XS_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= XS_IDLE;
      dir_q      <= 1'b0;
      ack        <= 1'b0;
      dev_rd     <= 1'b0;
      dev_wr     <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      dev_addr_o <= '0;
      mem_addr_o <= '0;
      wdata      <= '0;
    end else begin
      ack    <= 1'b0;
      dev_rd <= 1'b0;
      dev_wr <= 1'b0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      case (st)
        XS_IDLE: if (go) begin
          st         <= XS_READ;
          ack        <= 1'b1;
          dir_q      <= dir;
          dev_addr_o <= daddr;
          mem_addr_o <= maddr;
          if (dir) mem_rd <= 1'b1;
          else     dev_rd <= 1'b1;
        end
        XS_READ: st <= XS_WAIT;
        XS_WAIT: begin
          st    <= XS_WRITE;
          wdata <= dir_q ? mem_rdata : dev_rdata;
          if (dir_q) dev_wr <= 1'b1;
          else       mem_wr <= 1'b1;
        end
        default: st <= XS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
  import pdma_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [2:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          dev_dma_en,
  input  logic          dev_tx_empty,
  input  logic          dev_rx_full,
  output logic          dev_ack,
  output logic          dev_eot,
  output logic          dev_eot_early,
  output logic [AW-1:0] dev_addr,
  output logic          dev_rd,
  output logic          dev_wr,
  input  logic [DW-1:0] dev_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] wdata,
  output logic          irq_half,
  output logic          irq_done
);

  ctrl_t         ctrl_q;
  logic [AW-1:0] daddr_q;
  logic [AW-1:0] maddr_q;
  logic [CW-1:0] cnt_q;
  logic          half_q;
  logic          done_q;
  logic          xf_step;
  logic          chan_en;

  assign chan_en = ctrl_q.en;

  pdma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_re    (cfg_re),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .step      (xf_step),
    .ctrl_q    (ctrl_q),
    .daddr_q   (daddr_q),
    .maddr_q   (maddr_q),
    .cnt_q     (cnt_q),
    .half_q    (half_q),
    .done_q    (done_q),
    .eot_q     (dev_eot),
    .early_q   (dev_eot_early)
  );

  pdma_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .en         (chan_en),
    .dir        (ctrl_q.dir),
    .cnt_nz     (cnt_q != '0),
    .dma_en     (dev_dma_en),
    .tx_empty   (dev_tx_empty),
    .rx_full    (dev_rx_full),
    .daddr      (daddr_q),
    .maddr      (maddr_q),
    .dev_rdata  (dev_rdata),
    .mem_rdata  (mem_rdata),
    .ack        (dev_ack),
    .dev_rd     (dev_rd),
    .dev_wr     (dev_wr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .dev_addr_o (dev_addr),
    .mem_addr_o (mem_addr),
    .wdata      (wdata),
    .step       (xf_step)
  );

  assign irq_half = half_q & ctrl_q.half_ie;
  assign irq_done = done_q & ctrl_q.done_ie;

endmodule

// File: rtl/pdma_chan_chk.sv
module pdma_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          dev_ack,
  input logic          dev_rd,
  input logic          dev_wr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          dev_eot,
  input logic          dev_eot_early,
  input logic [CW-1:0] cnt,
  input logic          en,
  input logic          step
);

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> !dev_ack);

  p_ack_write_r4: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> ##2 (dev_wr || mem_wr));

  p_side_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(dev_wr && mem_wr) && !(dev_rd && mem_rd));

  p_step_dec_r6: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt == $past(cnt) - 1'b1));

  p_eot_zero_r7: assert property (@(posedge clk) disable iff (rst)
    dev_eot |-> (cnt == '0));

  p_early_one_r8: assert property (@(posedge clk) disable iff (rst)
    dev_eot_early |-> (cnt == CW'(1)));

  p_locked_r11: assert property (@(posedge clk) disable iff (rst)
    (en && !step) |=> $stable(cnt));

  p_no_zero_req_r12: assert property (@(posedge clk) disable iff (rst)
    dev_ack |-> (cnt != '0));

endmodule

bind pdma_chan pdma_chan_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dev_ack       (dev_ack),
  .dev_rd        (dev_rd),
  .dev_wr        (dev_wr),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .dev_eot       (dev_eot),
  .dev_eot_early (dev_eot_early),
  .cnt           (cnt_q),
  .en            (chan_en),
  .step          (xf_step)
);

// File: tb/test_pdma_chan.sv
module test_pdma_chan;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int CW = 6;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0, cfg_re = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic [RW-1:0] cfg_rdata;
  logic          dev_dma_en = 1'b0, dev_tx_empty = 1'b0, dev_rx_full = 1'b0;
  logic          dev_ack, dev_eot, dev_eot_early, dev_rd, dev_wr;
  logic [AW-1:0] dev_addr, mem_addr;
  logic          mem_rd, mem_wr, irq_half, irq_done;
  logic [DW-1:0] dev_q = '0, mem_q = '0, wdata;

  always #2.5 clk = ~clk;

  pdma_chan #(.DW(DW), .AW(AW), .CW(CW), .RW(RW)) i_pdma_chan (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_dma_en(dev_dma_en),
    .dev_tx_empty(dev_tx_empty), .dev_rx_full(dev_rx_full), .dev_ack(dev_ack),
    .dev_eot(dev_eot), .dev_eot_early(dev_eot_early), .dev_addr(dev_addr),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_rdata(dev_q), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_q), .wdata(wdata),
    .irq_half(irq_half), .irq_done(irq_done)
  );

  // memory and device models, one-cycle read latency
  logic [DW-1:0] ram [0:(1<<AW)-1];
  int dev_cnt = 0;
  initial for (int i = 0; i < (1<<AW); i++) ram[i] = DW'(i * 7 + 3);
  always @(posedge clk) begin
    if (mem_rd) mem_q <= ram[mem_addr];
    if (mem_wr) ram[mem_addr] <= wdata;
    if (dev_rd) begin
      dev_q   <= DW'(32'hC0 + dev_cnt);
      dev_cnt <= dev_cnt + 1;
    end
  end

  int n_checks = 0, n_fail = 0;
  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { bit to_mem; logic [AW-1:0] addr; logic [DW-1:0] data; } item_t;
  item_t exp_q[$];
  int dev_pred = 0;
  bit cur_dir = 1'b1;

  task automatic plan_tx(input int ma, input int da, input int n);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.to_mem = 1'b0; it.addr = AW'(da); it.data = ram[AW'(ma + k)];
      exp_q.push_back(it);
    end
  endtask

  task automatic plan_rx(input int ma, input int n);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.to_mem = 1'b1; it.addr = AW'(ma + k); it.data = DW'(32'hC0 + dev_pred);
      dev_pred++;
      exp_q.push_back(it);
    end
  endtask

  int cyc = 0, ack_cyc = -10, n_ack = 0, n_wr = 0, n_eot = 0, n_early = 0;
  int eot_at = 0, early_at = 0, half_at = 0;
  bit ack_prev = 0, half_prev = 0;

  always @(negedge clk) if (!rst) begin
    cyc++;
    if (dev_ack) begin
      chk("R4 ack single cycle", ack_prev, 0);
      chk("R4 read with ack", mem_rd | dev_rd, 1);
      chk("R5 source side", mem_rd, cur_dir);
      n_ack++; ack_cyc = cyc;
    end
    ack_prev = dev_ack;
    if (dev_wr || mem_wr) begin
      n_wr++;
      chk("R4 write two cycles after ack", cyc - ack_cyc, 2);
      if (exp_q.size() == 0) chk("R5 unexpected write", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk("R5 destination side", mem_wr, it.to_mem);
        chk("R5 destination address", mem_wr ? mem_addr : dev_addr, it.addr);
        chk("R5 data", wdata, it.data);
      end
    end
    if (dev_eot) begin n_eot++; eot_at = n_wr; end
    if (dev_eot_early) begin n_early++; early_at = n_wr; end
    if (irq_half && !half_prev) half_at = n_wr;
    half_prev = irq_half;
  end

  task automatic cw(input logic [2:0] a, input int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = RW'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cr(input logic [2:0] a, output int d);
    @(negedge clk); cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_re = 1'b0; d = int'(cfg_rdata);
  endtask

  task automatic wait_wr(input int target);
    int t = 0;
    while (n_wr < target && t < 3000) begin @(posedge clk); t++; end
    repeat (6) @(posedge clk);
    chk("R3 transfers completed", n_wr, target);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, b_wr, b_eot, b_early, b_ack;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 outputs idle", {dev_ack, dev_eot, dev_eot_early, dev_rd, dev_wr, mem_rd, mem_wr, irq_half, irq_done}, 0);
    for (int a = 0; a < 5; a++) begin cr(3'(a), v); chk("R1 register reset", v, 0); end

    // transmit, count 5
    cw(3'd2, 'h40); cw(3'd3, 'h10); cw(3'd4, 5);
    b_wr = n_wr; b_eot = n_eot; b_early = n_early;
    cur_dir = 1'b1; plan_tx('h10, 'h40, 5);
    dev_dma_en = 1'b1; dev_tx_empty = 1'b1;
    cw(3'd0, 'h3F);
    wait_wr(b_wr + 5);
    dev_tx_empty = 1'b0;
    chk("R5 scoreboard drained", exp_q.size(), 0);
    chk("R8 one early strobe", n_early - b_early, 1);
    chk("R8 early after fourth byte", early_at - b_wr, 4);
    chk("R7 one end strobe", n_eot - b_eot, 1);
    chk("R7 end after last byte", eot_at - b_wr, 5);
    chk("R9 half after third byte", half_at - b_wr, 3);
    cr(3'd4, v); chk("R6 count at zero", v, 0);
    cr(3'd3, v); chk("R6 memory address advanced", v, 'h15);
    cr(3'd2, v); chk("R6 device address fixed", v, 'h40);
    cr(3'd1, v); chk("R7 status flags", v, 3);
    cr(3'd0, v); chk("R2 control readback", v, 'h3F);
    chk("R10 both interrupts", {irq_half, irq_done}, 2'b11);
    cw(3'd1, 1); cr(3'd1, v); chk("R10 clear half only", v, 2);
    chk("R10 half irq low", {irq_half, irq_done}, 2'b01);
    cw(3'd1, 2); chk("R10 done irq low", irq_done, 0);

    // R11 locked while enabled, R12 zero count
    cw(3'd2, 'h77); cw(3'd3, 'h01); cw(3'd4, 9);
    cr(3'd2, v); chk("R11 device address kept", v, 'h40);
    cr(3'd3, v); chk("R11 memory address kept", v, 'h15);
    cr(3'd4, v); chk("R11 count kept", v, 0);
    b_ack = n_ack; dev_tx_empty = 1'b1;
    repeat (20) @(posedge clk);
    chk("R12 no request at zero count", n_ack - b_ack, 0);
    dev_tx_empty = 1'b0;

    // receive, count 2
    cw(3'd0, 0); cw(3'd2, 'h50); cw(3'd3, 'h30); cw(3'd4, 2);
    dev_tx_empty = 1'b1; dev_rx_full = 1'b0; dev_dma_en = 1'b1;
    cur_dir = 1'b0;
    cw(3'd0, 'h0D);
    b_ack = n_ack; repeat (20) @(posedge clk);
    chk("R3 wrong flag ignored", n_ack - b_ack, 0);
    dev_dma_en = 1'b0; dev_rx_full = 1'b1;
    repeat (20) @(posedge clk);
    chk("R3 peripheral enable required", n_ack - b_ack, 0);
    b_wr = n_wr; b_eot = n_eot; b_early = n_early;
    plan_rx('h30, 2);
    dev_dma_en = 1'b1;
    wait_wr(b_wr + 2);
    dev_rx_full = 1'b0; dev_tx_empty = 1'b0;
    chk("R8 early after first of two", early_at - b_wr, 1);
    chk("R8 one early strobe rx", n_early - b_early, 1);
    chk("R7 end after second", eot_at - b_wr, 2);
    chk("R9 half after first of two", half_at - b_wr, 1);
    chk("R5 rx data in memory", ram['h31], DW'(32'hC1));
    cr(3'd3, v); chk("R6 rx memory address", v, 'h32);
    cw(3'd1, 3);

    // receive, count 1
    cw(3'd0, 0); cw(3'd3, 'h40); cw(3'd4, 1);
    b_wr = n_wr; b_eot = n_eot; b_early = n_early;
    plan_rx('h40, 1);
    cw(3'd0, 'h0D);
    dev_rx_full = 1'b1;
    wait_wr(b_wr + 1);
    dev_rx_full = 1'b0;
    chk("R8 no early strobe for one byte", n_early - b_early, 0);
    chk("R7 end strobe single byte", n_eot - b_eot, 1);
    chk("R9 half with single byte", half_at - b_wr, 1);
    cw(3'd1, 3);

    // transmit, maximum count with address wrap
    cw(3'd0, 0); cw(3'd2, 'h41); cw(3'd3, 'hF0); cw(3'd4, 63);
    b_wr = n_wr; b_eot = n_eot; b_early = n_early;
    cur_dir = 1'b1; plan_tx('hF0, 'h41, 63);
    cw(3'd0, 'h0F);
    dev_tx_empty = 1'b1;
    wait_wr(b_wr + 63);
    dev_tx_empty = 1'b0;
    cr(3'd3, v); chk("R6 memory address wraps", v, 'h2F);
    chk("R9 half at 31 remaining", half_at - b_wr, 32);
    chk("R8 early at 62", early_at - b_wr, 62);
    chk("R7 end at 63", eot_at - b_wr, 63);
    chk("R5 scoreboard drained at end", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule